// File: doc/BRIEF.md
# USB Frame Stamp Capture Registers

This block keeps the frame number carried by the most recent start-of-frame token of a USB device port. An 8-bit CPU bus can read it as two bytes without seeing a torn value. The stored stamp is 16 bits wide. Its lower 11 bits hold the frame number and its upper bits always read as zero. The stamp loads on the same clock edge that a start-of-frame event is signalled. There is one exception: when substitute-marking is enabled and the start-of-frame is flagged as corrupted, the previous stamp is kept.

To stop the two bytes of one stamp from coming from different frames, reading the upper byte also copies the current lower byte into a byte-wide holding latch. A later read of the lower byte returns that latch and not the live value. Software must therefore read the upper byte first and the lower byte second. The block also keeps the 3-bit alternate setting delivered with the most recent Set Interface request. All stored fields are read-only and clear to zero on reset.

Top module: `frame_stamp_capture`

## Requirements
- R1: After reset the stamp, the holding latch and the alternate setting are all 0, so every register address reads 0x00.
- R2: A start-of-frame event that is not suppressed loads the frame number into the stamp at the same clock edge. A read at address 0 returns stamp bits 10..8 in read-data bits 2..0, with bits 7..3 equal to 0.
- R3: A start-of-frame event with the corrupted flag set while the substitute-mark enable is 1 leaves the stamp unchanged.
- R4: A start-of-frame event with the corrupted flag set while the substitute-mark enable is 0 still loads the frame number.
- R5: A read at address 0 copies stamp bits 7..0 into the holding latch at the same edge. A read at address 1 returns the latch, even if a start-of-frame event has changed the live stamp since the address-0 read.
- R6: When a start-of-frame update and an address-0 read occur in the same cycle, the read returns the old upper byte and the latch captures the old lower byte.
- R7: A read at address 1 that has no preceding address-0 read returns the latch's last value, which is 0x00 after reset.
- R8: A Set Interface event stores its 3-bit alternate setting at that edge. Address 2 returns it in bits 2..0, with bits 7..3 equal to 0. A read in the same cycle as the event returns the old value.
- R9: A read at address 3 returns 0x00, and read data is 0x00 whenever the read enable is low.
- R10: Changes on the frame-number input with no start-of-frame event leave the stamp unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sof_evt | input | 1 | Start-of-frame event strobe, one cycle |
| sof_frame | input | 11 | Decoded frame number of the token |
| sof_bad | input | 1 | The start-of-frame token was corrupted |
| mark_en | input | 1 | Substitute-mark enable: keep the old stamp on a corrupted token |
| seti_evt | input | 1 | Set Interface request received, one cycle |
| seti_alt | input | 3 | Alternate setting carried by the request |
| rd_en | input | 1 | Byte read strobe |
| rd_addr | input | 2 | Read address: 0 upper stamp byte, 1 lower stamp byte, 2 alternate setting |
| rd_data | output | 8 | Read data, combinational in the cycle of the read |

## Verification
The bench builds the block with its default widths: an 11-bit frame, an 8-bit bus and a 3-bit alternate setting. With these widths the upper byte has three live bits and five bits that must read as zero. Frame values 0x7FF, 0x5A3 and 0x0AB exercise every live bit of both bytes, including the all-ones boundary. Start-of-frame events are placed between the two byte reads and in the same cycle as an upper-byte read, which exercises the tearing cases.

// File: rtl/fsc_pkg.sv
package fsc_pkg;
    localparam int ADDR_W = 2;

    typedef enum logic [ADDR_W-1:0] {
        RA_HI   = 2'd0,
        RA_LO   = 2'd1,
        RA_ALT  = 2'd2,
        RA_NONE = 2'd3
    } reg_addr_e;
endpackage

// File: rtl/fsc_stamp_reg.sv
module fsc_stamp_reg #(
    parameter int FRAME_W = 11,
    parameter int ALT_W   = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sof_evt,
    input  logic [FRAME_W-1:0] sof_frame,
    input  logic               sof_bad,
    input  logic               mark_en,
    input  logic               seti_evt,
    input  logic [ALT_W-1:0]   seti_alt,
    output logic [FRAME_W-1:0] stamp_q,
    output logic [ALT_W-1:0]   alt_q
);
    typedef struct packed {
        logic [FRAME_W-1:0] stamp;
        logic [ALT_W-1:0]   alt;
    } state_t;

    state_t s_d, s_q;
    logic   take_sof;

    always_comb begin
        s_d      = s_q;
        // a corrupted token is only suppressed when substitute-marking is on
        take_sof = sof_evt && !(mark_en && sof_bad);
        if (take_sof) begin
            s_d.stamp = sof_frame;
        end
        if (seti_evt) begin
            s_d.alt = seti_alt;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign stamp_q = s_q.stamp;
    assign alt_q   = s_q.alt;
endmodule

// File: rtl/fsc_shadow.sv
module fsc_shadow #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout
);
    typedef struct packed {
        logic [DATA_W-1:0] byte_val;
    } state_t;

    state_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (load) begin
            s_d.byte_val = din;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign dout = s_q.byte_val;
endmodule

// File: rtl/fsc_read_mux.sv
module fsc_read_mux
    import fsc_pkg::*;
#(
    parameter int FRAME_W = 11,
    parameter int ALT_W   = 3,
    parameter int DATA_W  = 8
) (
    input  logic               rd_en,
    input  logic [ADDR_W-1:0]  rd_addr,
    input  logic [FRAME_W-1:0] stamp,
    input  logic [DATA_W-1:0]  shadow,
    input  logic [ALT_W-1:0]   alt,
    output logic [DATA_W-1:0]  rd_data
);
    localparam int STAMP_W = 2 * DATA_W;

    logic [STAMP_W-1:0] stamp_ext;

    assign stamp_ext = STAMP_W'(stamp);

    always_comb begin
        rd_data = '0;
        if (rd_en) begin
            case (reg_addr_e'(rd_addr))
                RA_HI:   rd_data = stamp_ext[STAMP_W-1:DATA_W];
                RA_LO:   rd_data = shadow;
                RA_ALT:  rd_data = DATA_W'(alt);
                default: rd_data = '0;
            endcase
        end
    end
endmodule

// File: rtl/frame_stamp_capture.sv
module frame_stamp_capture
    import fsc_pkg::*;
#(
    parameter int FRAME_W = 11,
    parameter int ALT_W   = 3,
    parameter int DATA_W  = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sof_evt,
    input  logic [FRAME_W-1:0] sof_frame,
    input  logic               sof_bad,
    input  logic               mark_en,
    input  logic               seti_evt,
    input  logic [ALT_W-1:0]   seti_alt,
    input  logic               rd_en,
    input  logic [ADDR_W-1:0]  rd_addr,
    output logic [DATA_W-1:0]  rd_data
);
    localparam int STAMP_W = 2 * DATA_W;

    logic [FRAME_W-1:0] stamp_q;
    logic [ALT_W-1:0]   alt_q;
    logic [DATA_W-1:0]  shadow_q;
    logic [STAMP_W-1:0] stamp_ext;
    logic               hi_read;

    assign stamp_ext = STAMP_W'(stamp_q);
    assign hi_read   = rd_en && (rd_addr == RA_HI);

    fsc_stamp_reg #(.FRAME_W(FRAME_W), .ALT_W(ALT_W)) u_stamp (
        .clk       (clk),
        .rst_n     (rst_n),
        .sof_evt   (sof_evt),
        .sof_frame (sof_frame),
        .sof_bad   (sof_bad),
        .mark_en   (mark_en),
        .seti_evt  (seti_evt),
        .seti_alt  (seti_alt),
        .stamp_q   (stamp_q),
        .alt_q     (alt_q)
    );

    // the latch takes the pre-edge low byte, so a same-cycle update cannot tear
    fsc_shadow #(.DATA_W(DATA_W)) u_shadow (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (hi_read),
        .din   (stamp_ext[DATA_W-1:0]),
        .dout  (shadow_q)
    );

    fsc_read_mux #(.FRAME_W(FRAME_W), .ALT_W(ALT_W), .DATA_W(DATA_W)) u_mux (
        .rd_en   (rd_en),
        .rd_addr (rd_addr),
        .stamp   (stamp_q),
        .shadow  (shadow_q),
        .alt     (alt_q),
        .rd_data (rd_data)
    );
endmodule

// File: rtl/fsc_checker.sv
module fsc_checker
    import fsc_pkg::*;
#(
    parameter int FRAME_W = 11,
    parameter int ALT_W   = 3,
    parameter int DATA_W  = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic               sof_evt,
    input logic [FRAME_W-1:0] sof_frame,
    input logic               sof_bad,
    input logic               mark_en,
    input logic               seti_evt,
    input logic [ALT_W-1:0]   seti_alt,
    input logic               rd_en,
    input logic [ADDR_W-1:0]  rd_addr,
    input logic [DATA_W-1:0]  rd_data,
    input logic [FRAME_W-1:0] stamp_q,
    input logic [DATA_W-1:0]  shadow_q,
    input logic [ALT_W-1:0]   alt_q
);
    localparam int HI_LIVE = FRAME_W - DATA_W;

    a_r2_sof_load: assert property (@(posedge clk) disable iff (!rst_n)
        (sof_evt && !(mark_en && sof_bad)) |=> (stamp_q == $past(sof_frame)));

    a_r3_bad_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (sof_evt && mark_en && sof_bad) |=> $stable(stamp_q));

    a_r4_bad_load: assert property (@(posedge clk) disable iff (!rst_n)
        (sof_evt && !mark_en && sof_bad) |=> (stamp_q == $past(sof_frame)));

    a_r10_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !sof_evt |=> $stable(stamp_q));

    a_r5_latch_load: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && rd_addr == RA_HI) |=> (shadow_q == $past(stamp_q[DATA_W-1:0])));

    a_r7_latch_keep: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_en && rd_addr == RA_HI) |=> $stable(shadow_q));

    a_r8_alt_store: assert property (@(posedge clk) disable iff (!rst_n)
        seti_evt |=> (alt_q == $past(seti_alt)));

    a_r2_hi_zero_bits: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && rd_addr == RA_HI) |-> (rd_data[DATA_W-1:HI_LIVE] == '0));

    a_r9_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |-> (rd_data == '0));
endmodule

bind frame_stamp_capture fsc_checker #(
    .FRAME_W(FRAME_W), .ALT_W(ALT_W), .DATA_W(DATA_W)
) u_fsc_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .sof_evt   (sof_evt),
    .sof_frame (sof_frame),
    .sof_bad   (sof_bad),
    .mark_en   (mark_en),
    .seti_evt  (seti_evt),
    .seti_alt  (seti_alt),
    .rd_en     (rd_en),
    .rd_addr   (rd_addr),
    .rd_data   (rd_data),
    .stamp_q   (stamp_q),
    .shadow_q  (shadow_q),
    .alt_q     (alt_q)
);

// File: tb/test_frame_stamp_capture.sv
module test_frame_stamp_capture;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sof_evt = 1'b0;
    logic [10:0] sof_frame = '0;
    logic        sof_bad = 1'b0;
    logic        mark_en = 1'b0;
    logic        seti_evt = 1'b0;
    logic [2:0]  seti_alt = '0;
    logic        rd_en = 1'b0;
    logic [1:0]  rd_addr = '0;
    logic [7:0]  rd_data;

    typedef struct {
        logic [7:0] exp;
        string      tag;
    } item_t;

    item_t exp_q[$];
    int    compared = 0;
    int    mismatched = 0;
    bit    done = 0;

    // reference state built from the requirements
    logic [10:0] m_stamp = '0;
    logic [7:0]  m_latch = '0;
    logic [2:0]  m_alt = '0;

    always #2 clk = ~clk;

    frame_stamp_capture i_frame_stamp_capture (
        .clk       (clk),
        .rst_n     (rst_n),
        .sof_evt   (sof_evt),
        .sof_frame (sof_frame),
        .sof_bad   (sof_bad),
        .mark_en   (mark_en),
        .seti_evt  (seti_evt),
        .seti_alt  (seti_alt),
        .rd_en     (rd_en),
        .rd_addr   (rd_addr),
        .rd_data   (rd_data)
    );

    // one cycle of stimulus; optionally queues the expected read data
    task automatic step(input bit sof, input logic [10:0] frm, input bit bad,
                        input bit mark, input bit seti, input logic [2:0] alt,
                        input bit rd, input logic [1:0] addr,
                        input bit chk, input string tag);
        item_t it;
        logic [15:0] ext;
        @(negedge clk);
        sof_evt = sof; sof_frame = frm; sof_bad = bad; mark_en = mark;
        seti_evt = seti; seti_alt = alt; rd_en = rd; rd_addr = addr;
        ext = {5'b0, m_stamp};
        it.exp = 8'h00;
        if (rd) begin
            case (addr)
                2'd0: it.exp = ext[15:8];
                2'd1: it.exp = m_latch;
                2'd2: it.exp = {5'b0, m_alt};
                default: it.exp = 8'h00;
            endcase
        end
        it.tag = tag;
        if (chk) exp_q.push_back(it);
        if (rd && addr == 2'd0) m_latch = ext[7:0];
        if (sof && !(mark && bad)) m_stamp = frm;
        if (seti) m_alt = alt;
    endtask

    task automatic rd(input logic [1:0] addr, input string tag);
        step(0, sof_frame, 0, mark_en, 0, 3'd0, 1, addr, 1, tag);
    endtask

    task automatic sof(input logic [10:0] frm, input bit bad, input bit mark);
        step(1, frm, bad, mark, 0, 3'd0, 0, 2'd0, 0, "");
    endtask

    // monitor: compares one queued item per cycle, away from the clock edge
    initial begin
        forever begin
            @(negedge clk);
            #1;
            if (exp_q.size() > 0) begin
                item_t it;
                it = exp_q.pop_front();
                compared++;
                if (rd_data !== it.exp) begin
                    mismatched++;
                    $display("FAIL %s: rd_data actual 0x%02h expected 0x%02h",
                             it.tag, rd_data, it.exp);
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            mismatched++;
            $display("FAIL watchdog: run hung, actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R7 and R1: latch reads 0 before any upper-byte read
        rd(2'd1, "R7");
        rd(2'd0, "R1");
        rd(2'd2, "R1");

        // R2 / R5 basic pair
        sof(11'h5A3, 0, 0);
        rd(2'd0, "R2");
        rd(2'd1, "R5");

        // R5: update between the two byte reads
        sof(11'h7FF, 0, 0);
        rd(2'd0, "R2");
        sof(11'h123, 0, 0);
        rd(2'd1, "R5");
        rd(2'd0, "R5");
        rd(2'd1, "R5");

        // R3: corrupted token with marking on is ignored
        sof(11'h456, 1, 1);
        rd(2'd0, "R3");
        rd(2'd1, "R3");

        // R4: corrupted token with marking off still loads
        sof(11'h456, 1, 0);
        rd(2'd0, "R4");
        rd(2'd1, "R4");

        // R6: update coincides with upper-byte read
        step(1, 11'h0AB, 0, 0, 0, 3'd0, 1, 2'd0, 1, "R6");
        rd(2'd1, "R6");
        rd(2'd0, "R6");
        rd(2'd1, "R6");

        // R10: frame input moves without an event
        step(0, 11'h3CC, 0, 0, 0, 3'd0, 0, 2'd0, 0, "");
        rd(2'd0, "R10");
        rd(2'd1, "R10");

        // R8: alternate setting
        step(0, 11'h3CC, 0, 0, 1, 3'd5, 0, 2'd0, 0, "");
        rd(2'd2, "R8");
        step(0, 11'h3CC, 0, 0, 1, 3'd2, 1, 2'd2, 1, "R8");
        rd(2'd2, "R8");
        step(0, 11'h3CC, 0, 0, 1, 3'd7, 0, 2'd0, 0, "");
        rd(2'd2, "R8");

        // R9: unused address and idle bus
        rd(2'd3, "R9");
        step(0, 11'h3CC, 0, 0, 0, 3'd0, 0, 2'd0, 1, "R9");
        step(0, 11'h3CC, 0, 0, 0, 3'd0, 0, 2'd2, 1, "R9");

        step(0, 11'h0, 0, 0, 0, 3'd0, 0, 2'd0, 0, "");
        repeat (3) @(negedge clk);
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end
endmodule